// File: doc/BRIEF.md
# Address Translation Buffer with Two-Level Table Walker

This block turns 32-bit virtual addresses into 24-bit physical addresses for 4 KB pages. The low 12 bits of the address are the byte offset and pass through unchanged. The 20 bits above them form the virtual page number, which is compared at once against every entry of a small fully associative buffer. A match returns the stored 12-bit frame number in the same cycle.

When no entry matches, a hardware walker makes two reads on a memory port. It first reads the directory word, found from the directory base input and the top ten address bits. That word gives the frame of a page table, and the walker then reads the entry selected by the next ten address bits. A valid entry is written into the buffer and the request then completes as a hit. An invalid directory word or an invalid table entry ends the request with a page fault.

Each buffer entry carries dirty and used flags. A write access marks its mapping dirty, and every access marks it used. The used flags guide which entry a refill replaces.

Top module: `tlb_walker`

## Requirements
- R1: After reset every entry is invalid, so the first access to any page starts a walk, and `req_ready` stays low whenever `req_valid` is low.
- R2: A completed translation outputs `resp_paddr` = {frame[11:0], req_vaddr[11:0]}.
- R3: A request whose page number matches a valid entry gets `req_ready` in the cycle it is presented, and no memory read is issued.
- R4: On a miss the first read goes to `dir_base` + {vaddr[31:22], 2'b00}. If that word is valid, the second read goes to {word[11:0], vaddr[21:12], 2'b00}. Both words use the same layout: bits 11:0 hold the frame, bit 12 is valid, bit 13 is dirty and bit 14 is used. `mem_req` is only raised while a request is pending and not yet completed.
- R5: After a refill the pending request completes with the new frame, and later accesses to the same page hit without any memory read.
- R6: A table entry with bit 12 clear ends the request with `req_ready` and `resp_fault` high. Nothing is installed, so a repeat of the same access walks again with two reads.
- R7: A directory word with bit 12 clear faults after a single read.
- R8: `resp_dirty` shows the mapping's dirty flag including the current access. A refill loads the flag from entry bit 13, and any completed write sets it for all later accesses to that page.
- R9: A refill fills an invalid entry first, taking the lowest index.
- R10: When all entries are valid, a refill replaces the lowest-index entry whose used flag is 0. If every used flag is 1, all used flags are cleared and entry 0 is replaced. A refill loads the used flag from entry bit 14, and every completed access sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translate request pending; held until `req_ready` |
| req_ready | output | 1 | Request completes this cycle (hit or fault) |
| req_vaddr | input | 32 | Virtual address, held stable while pending |
| req_write | input | 1 | Access is a write |
| resp_paddr | output | 24 | Physical address, valid with `req_ready` and no fault |
| resp_fault | output | 1 | Page fault, valid with `req_ready` |
| resp_dirty | output | 1 | Dirty flag of the mapping after this access |
| dir_base | input | 24 | Physical byte address of the directory page |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 24 | Read byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 15 | Returned directory or table word |

## Verification
The case where two updates land in one cycle is a refill into a full buffer whose used flags are all set. In that cycle every used flag is cleared and entry 0 is overwritten with the new mapping. To reach it, four pages are loaded and each is touched again, and then a fifth page misses. The result is judged at the ports by counting memory reads. The fifth page must then hit. The other three old pages must still hit, which shows that only entry 0 was overwritten. Because the clearing really happened, the next miss must replace entry 1 and not entry 0, and this shows in which later accesses walk again.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int ENTRIES = 4,
  parameter int DIR_W   = 10,
  parameter int PT_W    = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [DIR_W+PT_W+OFF_W-1:0] req_vaddr,
  input  logic                       req_write,
  output logic [FRAME_W+OFF_W-1:0]   resp_paddr,
  output logic                       resp_fault,
  output logic                       resp_dirty,
  input  logic [FRAME_W+OFF_W-1:0]   dir_base,
  output logic                       mem_req,
  output logic [FRAME_W+OFF_W-1:0]   mem_addr,
  input  logic                       mem_rvalid,
  input  logic [FRAME_W+2:0]         mem_rdata
);
  localparam int VPN_W = DIR_W + PT_W;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int V_BIT = FRAME_W;
  localparam int D_BIT = FRAME_W + 1;
  localparam int U_BIT = FRAME_W + 2;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_PT, S_FAULT} state_t;
  state_t state;

  logic [ENTRIES-1:0] e_valid, e_dirty, e_used, hit_vec;
  logic [VPN_W-1:0]   e_vpn   [ENTRIES];
  logic [FRAME_W-1:0] e_frame [ENTRIES];

  wire [VPN_W-1:0] vpn     = req_vaddr[VA_W-1:OFF_W];
  wire [DIR_W-1:0] dir_off = req_vaddr[VA_W-1:OFF_W+PT_W];
  wire [PT_W-1:0]  pt_off  = req_vaddr[OFF_W+PT_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = e_valid[i] && (e_vpn[i] == vpn);
  end

  logic [FRAME_W-1:0] hit_frame;
  logic               hit_dirty;
  always_comb begin
    hit_frame = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_frame = hit_frame | e_frame[i];
        hit_dirty = hit_dirty | e_dirty[i];
      end
    end
  end

  logic [IDX_W-1:0] vic;
  logic             clear_all, found;
  always_comb begin
    vic = '0;
    found = 1'b0;
    clear_all = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !e_valid[i]) begin vic = IDX_W'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !e_used[i]) begin vic = IDX_W'(i); found = 1'b1; end
    if (!found) clear_all = 1'b1;
  end

  wire hit  = |hit_vec;
  wire take = req_valid && (state == S_IDLE) && hit;

  assign req_ready  = take || (state == S_FAULT);
  assign resp_fault = (state == S_FAULT);
  assign resp_paddr = {hit_frame, req_vaddr[OFF_W-1:0]};
  assign resp_dirty = hit_dirty | req_write;

  assign mem_req  = ((state == S_IDLE) && req_valid && !hit) ||
                    ((state == S_DIR) && mem_rvalid && mem_rdata[V_BIT]);
  assign mem_addr = (state == S_IDLE) ? dir_base + PA_W'({dir_off, 2'b00})
                                      : PA_W'({mem_rdata[FRAME_W-1:0], pt_off, 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      e_valid <= '0;
      e_dirty <= '0;
      e_used  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i]   <= '0;
        e_frame[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            if (hit) begin
              for (int i = 0; i < ENTRIES; i++)
                if (hit_vec[i]) begin
                  e_used[i] <= 1'b1;
                  if (req_write) e_dirty[i] <= 1'b1;
                end
            end else begin
              state <= S_DIR;
            end
          end
        S_DIR:
          if (mem_rvalid) state <= mem_rdata[V_BIT] ? S_PT : S_FAULT;
        S_PT:
          if (mem_rvalid) begin
            if (!mem_rdata[V_BIT]) begin
              state <= S_FAULT;
            end else begin
              if (clear_all) e_used <= '0;
              e_valid[vic] <= 1'b1;
              e_vpn[vic]   <= vpn;
              e_frame[vic] <= mem_rdata[FRAME_W-1:0];
              e_dirty[vic] <= mem_rdata[D_BIT];
              e_used[vic]  <= mem_rdata[U_BIT];
              state <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 24,
  parameter int PTE_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic [PA_W-1:0]  resp_paddr,
  input logic             resp_fault,
  input logic             resp_dirty,
  input logic [PA_W-1:0]  dir_base,
  input logic             mem_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic             mem_rvalid,
  input logic [PTE_W-1:0] mem_rdata
);
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready); // R1

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !resp_fault) |-> resp_paddr[11:0] == req_vaddr[11:0]); // R2

  AST_READ_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (req_valid && !req_ready)); // R4

  AST_FAULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && resp_fault) |-> $past(mem_rvalid)); // R6

  AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !resp_fault &&
     $past(req_valid && req_ready && !resp_fault && req_write) &&
     req_vaddr[VA_W-1:12] == $past(req_vaddr[VA_W-1:12])) |-> resp_dirty); // R8
endmodule

bind tlb_walker tlb_walker_chk chk_i (.*);

// File: tb/tlb_walker_tb_top.sv
module tlb_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [23:0] resp_paddr;
  logic        resp_fault, resp_dirty;
  logic [23:0] dir_base = 24'h100000;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [14:0] mem_rdata = '0;

  int compared = 0, mismatched = 0, cycles = 0;
  int nreq = 0;
  logic [23:0] addr_log [2];

  always #2 clk = ~clk;

  tlb_walker dut_i (.*);

  function automatic logic [14:0] mem_word(input logic [23:0] a);
    logic [11:0] f;
    logic [9:0]  o;
    f = a[23:12];
    o = a[11:2];
    if (f == 12'h100) return {2'b00, o != 10'd3, 12'h200 + {2'b00, o}};
    return {1'b0, o == 10'd9, o != 10'd5, {f[5:0], o[5:0]} ^ 12'h0A5};
  endfunction

  function automatic logic [11:0] exp_frame(input logic [31:0] va);
    logic [11:0] f;
    f = 12'h200 + {2'b00, va[31:22]};
    return {f[5:0], va[17:12]} ^ 12'h0A5;
  endfunction

  logic        p1_v = 1'b0, p2_v = 1'b0;
  logic [23:0] p1_a = '0, p2_a = '0;
  always @(posedge clk) begin
    p1_v <= mem_req;
    p1_a <= mem_addr;
    p2_v <= p1_v;
    p2_a <= p1_a;
    mem_rvalid <= p2_v;
    mem_rdata  <= p2_v ? mem_word(p2_a) : 15'h0;
    if (mem_req) begin
      if (nreq < 2) addr_log[nreq] <= mem_addr;
      nreq <= nreq + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic        g_fault, g_dirty;
  logic [23:0] g_pa;
  int          g_cyc, g_req;

  task automatic translate(input logic [31:0] va, input logic wr);
    @(negedge clk);
    nreq = 0;
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    g_cyc = 0;
    #1;
    while (!req_ready && g_cyc < 200) begin
      @(negedge clk);
      #1;
      g_cyc++;
    end
    g_fault = resp_fault;
    g_dirty = resp_dirty;
    g_pa = resp_paddr;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_write = 1'b0;
    g_req = nreq;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] va_of(input int d, input int p, input int off);
    return {10'(d), 10'(p), 12'(off)};
  endfunction

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    #1;
    check(req_ready == 1'b0, "R1 ready idle", 32'(req_ready), 0);
    check(mem_req == 1'b0, "R1 no read idle", 32'(mem_req), 0);
  endtask

  task automatic t_walk();
    logic [31:0] va;
    va = va_of(1, 2, 12'h345);
    translate(va, 1'b0);
    check(g_req == 2, "R4 two reads", 32'(g_req), 2);
    check(addr_log[0] == 24'h100004, "R4 dir addr", 32'(addr_log[0]), 32'h100004);
    check(addr_log[1] == 24'h201008, "R4 table addr", 32'(addr_log[1]), 32'h201008);
    check(g_cyc > 0, "R1 first access walks", 32'(g_cyc), 1);
    check(!g_fault && g_pa == {exp_frame(va), 12'h345}, "R5 refill result",
          32'(g_pa), 32'({exp_frame(va), 12'h345}));
    va = va_of(1, 2, 12'hABC);
    translate(va, 1'b0);
    check(g_req == 0 && g_cyc == 0, "R3 hit no read", 32'(g_req), 0);
    check(g_pa == {exp_frame(va), 12'hABC}, "R2 paddr", 32'(g_pa), 32'({exp_frame(va), 12'hABC}));
  endtask

  task automatic t_dirty();
    translate(va_of(2, 9, 0), 1'b0);
    check(g_dirty == 1'b1, "R8 dirty from entry", 32'(g_dirty), 1);
    translate(va_of(2, 7, 0), 1'b0);
    check(g_dirty == 1'b0, "R8 clean read", 32'(g_dirty), 0);
    translate(va_of(2, 7, 4), 1'b1);
    check(g_dirty == 1'b1, "R8 write dirty", 32'(g_dirty), 1);
    translate(va_of(2, 7, 8), 1'b0);
    check(g_dirty == 1'b1 && g_req == 0, "R8 dirty kept", 32'(g_dirty), 1);
  endtask

  task automatic t_faults();
    translate(va_of(1, 5, 0), 1'b0);
    check(g_fault == 1'b1 && g_req == 2, "R6 table fault", 32'(g_req), 2);
    translate(va_of(1, 5, 0), 1'b0);
    check(g_fault == 1'b1 && g_req == 2, "R6 no install", 32'(g_req), 2);
    translate(va_of(3, 1, 0), 1'b0);
    check(g_fault == 1'b1 && g_req == 1, "R7 dir fault", 32'(g_req), 1);
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      translate(va_of(4, 10 + i, 0), 1'b0);
      check(g_req == 2, "R9 fill miss", 32'(g_req), 2);
    end
    for (int i = 0; i < 4; i++) begin
      translate(va_of(4, 10 + i, 0), 1'b0);
      check(g_req == 0, "R9 filled entries hit", 32'(g_req), 0);
    end
    translate(va_of(4, 20, 0), 1'b0);
    check(g_req == 2, "R10 fifth page walks", 32'(g_req), 2);
    translate(va_of(4, 20, 0), 1'b0);
    check(g_req == 0, "R10 fifth page hits", 32'(g_req), 0);
    translate(va_of(4, 21, 0), 1'b0);
    check(g_req == 2, "R10 sixth page walks", 32'(g_req), 2);
    translate(va_of(4, 12, 0), 1'b0);
    check(g_req == 0, "R10 entry 2 kept", 32'(g_req), 0);
    translate(va_of(4, 13, 0), 1'b0);
    check(g_req == 0, "R10 entry 3 kept", 32'(g_req), 0);
    translate(va_of(4, 11, 0), 1'b0);
    check(g_req == 2, "R10 unused entry 1 replaced", 32'(g_req), 2);
    translate(va_of(4, 20, 0), 1'b0);
    check(g_req == 2, "R10 clear-all evicted entry 0", 32'(g_req), 2);
  endtask

  initial begin
    t_reset();
    t_walk();
    t_dirty();
    t_faults();
    t_replace();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule